// File: doc/BRIEF.md
# Per-Lane Divergence Tracker with Inactivity Counters

This block follows structured control flow for a group of SIMD lanes that share one instruction stream. A sequencer reports each structured control event (opening a conditional, switching to its alternative branch, closing it) together with a per-lane condition vector. The block answers with a per-lane enable mask that the execution lanes use to discard or keep each instruction, and with a hint that tells the sequencer it may jump over a conditional body when no enabled lane would execute it.

Instead of a stack of saved masks, every lane owns one small up/down counter that records how many enclosing conditionals have switched it off. A lane runs only while its counter is zero. One shared nesting-depth register guards the counters: a conditional opened at the deepest supported level is rejected with an overflow pulse, and an alternative or close with nothing open is rejected with an underflow pulse. In both cases no state changes.

Top module: `lane_divergence_ctrl`

## Requirements
- R1: Output bit `active_mask[i]` is 1 exactly when lane i's inactivity counter is zero.
- R2: On an open event (`ev_kind` = 2'd1) a lane with a nonzero counter increments it, an enabled lane whose `ev_cond` bit is 0 moves to 1, and an enabled lane whose `ev_cond` bit is 1 stays enabled.
- R3: On an alternative event (`ev_kind` = 2'd2) a lane at count 0 moves to 1, a lane at count 1 moves to 0, and a lane at a higher count keeps it.
- R4: On a close event (`ev_kind` = 2'd3) every lane with a nonzero counter decrements it; enabled lanes stay enabled.
- R5: After any properly nested sequence of open, optional alternative and close events, every lane is enabled again.
- R6: `skip_body` is 1, in the same cycle as an open event, exactly when no currently enabled lane has its `ev_cond` bit set; it is 0 for every other event kind.
- R7: An open event at nesting depth 2^CNT_W-1 (15 with default parameters) pulses `err_overflow` for one cycle after the event and leaves every counter and the depth unchanged.
- R8: An alternative or close event at nesting depth 0 pulses `err_underflow` for one cycle after the event and leaves all state unchanged.
- R9: While `rst` is high at a clock edge all counters and the depth clear, so after reset `active_mask` is all ones and both error outputs are 0.
- R10: State changes appear on the clock edge that samples the event; an idle event (`ev_kind` = 2'd0) changes no state and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ev_kind | input | 2 | Event: 0 idle, 1 open, 2 alternative, 3 close |
| ev_cond | input | LANES | Per-lane branch condition for an open event |
| active_mask | output | LANES | Per-lane enable, 1 when the lane runs |
| skip_body | output | 1 | Open event with no enabled lane taking the body |
| err_overflow | output | 1 | One-cycle pulse: open event rejected at maximum depth |
| err_underflow | output | 1 | One-cycle pulse: alternative or close rejected at depth 0 |

## Verification
The bench builds the block with six lanes and 3-bit counters, so the deepest level is 7 and saturation is reached after seven opens instead of fifteen. That makes it cheap to drive every lane to the maximum count, hit the rejected eighth open with lanes at mixed counts, and then unwind back to all-enabled. Six lanes leave room for condition patterns where some lanes are switched off at different depths, so alternative events see counts 0, 1 and above at once.

// File: rtl/divctl_pkg.sv
package divctl_pkg;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_OPEN  = 2'd1,
        EV_ALT   = 2'd2,
        EV_CLOSE = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } div_err_t;

    function automatic logic closes_scope(ev_kind_e k);
        return (k == EV_ALT) || (k == EV_CLOSE);
    endfunction

endpackage

// File: rtl/divctl_lane.sv
module divctl_lane
    import divctl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ev_kind_e         ev_kind,
    input  logic             cond,
    input  logic             hold,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!hold) begin
            unique case (ev_kind)
                EV_OPEN: begin
                    if (cnt_q != ZERO)  cnt_d = cnt_q + ONE;
                    else if (!cond)     cnt_d = ONE;
                end
                EV_ALT: begin
                    if (cnt_q == ZERO)     cnt_d = ONE;
                    else if (cnt_q == ONE) cnt_d = ZERO;
                end
                EV_CLOSE: begin
                    if (cnt_q != ZERO)  cnt_d = cnt_q - ONE;
                end
                default: cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= ZERO;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/divctl_depth.sv
module divctl_depth
    import divctl_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  ev_kind_e ev_kind,
    output logic     hold,
    output div_err_t err_q
);
    localparam logic [CNT_W-1:0] DEPTH_MAX = '1;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] depth_q;
    div_err_t         err_now;

    always_comb begin
        err_now.ovf = (ev_kind == EV_OPEN) && (depth_q == DEPTH_MAX);
        err_now.unf = closes_scope(ev_kind) && (depth_q == '0);
    end

    assign hold = err_now.ovf | err_now.unf;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            err_q   <= '0;
        end else begin
            err_q <= err_now;
            if (!hold) begin
                if (ev_kind == EV_OPEN)       depth_q <= depth_q + ONE;
                else if (ev_kind == EV_CLOSE) depth_q <= depth_q - ONE;
            end
        end
    end
endmodule

// File: rtl/lane_divergence_ctrl.sv
module lane_divergence_ctrl
    import divctl_pkg::*;
#(
    parameter int LANES = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       ev_kind,
    input  logic [LANES-1:0] ev_cond,
    output logic [LANES-1:0] active_mask,
    output logic             skip_body,
    output logic             err_overflow,
    output logic             err_underflow
);
    ev_kind_e ev;
    logic     hold;
    div_err_t err_q;

    assign ev = ev_kind_e'(ev_kind);

    divctl_depth #(.CNT_W(CNT_W)) u_depth (
        .clk     (clk),
        .rst     (rst),
        .ev_kind (ev),
        .hold    (hold),
        .err_q   (err_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [CNT_W-1:0] cnt;
        divctl_lane #(.CNT_W(CNT_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .ev_kind (ev),
            .cond    (ev_cond[i]),
            .hold    (hold),
            .cnt_o   (cnt)
        );
        assign active_mask[i] = (cnt == '0);
    end

    assign skip_body     = (ev == EV_OPEN) && ((ev_cond & active_mask) == '0);
    assign err_overflow  = err_q.ovf;
    assign err_underflow = err_q.unf;
endmodule

// File: rtl/divctl_checker.sv
module divctl_checker #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       ev_kind,
    input logic [LANES-1:0] ev_cond,
    input logic [LANES-1:0] active_mask,
    input logic             skip_body,
    input logic             err_overflow,
    input logic             err_underflow
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_q) AST_RESET_ALL_ACTIVE: assert (active_mask == '1 && !err_overflow && !err_underflow); // R9
    end

    AST_OPEN_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        ev_kind == 2'd1 |=> (active_mask & ~$past(active_mask)) == '0); // R2

    AST_ALT_FLIP_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ev_kind == 2'd2 |=> ((active_mask & $past(active_mask)) == '0) || err_underflow); // R3

    AST_CLOSE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ev_kind == 2'd3 |=> (active_mask & $past(active_mask)) == $past(active_mask)); // R4

    AST_SKIP_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
        skip_body |=> (active_mask == '0) || err_overflow); // R6

    AST_SKIP_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
        ev_kind != 2'd1 |-> !skip_body); // R6

    AST_NO_OVERFLOW_CHANGE: assert property (@(posedge clk) disable iff (rst)
        err_overflow |-> $stable(active_mask)); // R7

    AST_NO_UNDERFLOW_CHANGE: assert property (@(posedge clk) disable iff (rst)
        err_underflow |-> $stable(active_mask)); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        ev_kind == 2'd0 |=> $stable(active_mask) && !err_overflow && !err_underflow); // R10

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(err_overflow && err_underflow)); // R7
endmodule

bind lane_divergence_ctrl divctl_checker #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_kind       (ev_kind),
    .ev_cond       (ev_cond),
    .active_mask   (active_mask),
    .skip_body     (skip_body),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/lane_divergence_ctrl_tb.sv
module lane_divergence_ctrl_tb;
    localparam int LANES = 6;
    localparam int CNT_W = 3;
    localparam int MAXD  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       ev_kind = 2'd0;
    logic [LANES-1:0] ev_cond = '0;
    logic [LANES-1:0] active_mask;
    logic             skip_body, err_overflow, err_underflow;

    always #10 clk = ~clk;

    lane_divergence_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_cond(ev_cond),
        .active_mask(active_mask), .skip_body(skip_body),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    typedef struct {
        logic [LANES-1:0] mask;
        logic             ovf;
        logic             unf;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   mdl_cnt [LANES];
    int   mdl_depth = 0;
    bit   done = 0;

    function automatic logic [LANES-1:0] mdl_mask();
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (mdl_cnt[i] == 0);
        return m;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one event, check skip in-cycle, push expected next state
    task automatic do_ev(logic [1:0] kind, logic [LANES-1:0] cond, string tag);
        exp_t e;
        logic exp_skip;
        @(negedge clk);
        ev_kind = kind;
        ev_cond = cond;
        #1;
        exp_skip = (kind == 2'd1) && ((cond & mdl_mask()) == '0);
        check({tag, "/R6 skip"}, {31'd0, skip_body}, {31'd0, exp_skip});
        e.ovf = (kind == 2'd1) && (mdl_depth == MAXD);
        e.unf = (kind >= 2'd2) && (mdl_depth == 0);
        if (!e.ovf && !e.unf) begin
            for (int i = 0; i < LANES; i++) begin
                case (kind)
                    2'd1: if (mdl_cnt[i] != 0) mdl_cnt[i]++; else if (!cond[i]) mdl_cnt[i] = 1;
                    2'd2: if (mdl_cnt[i] == 0) mdl_cnt[i] = 1; else if (mdl_cnt[i] == 1) mdl_cnt[i] = 0;
                    2'd3: if (mdl_cnt[i] != 0) mdl_cnt[i]--;
                    default: ;
                endcase
            end
            if (kind == 2'd1) mdl_depth++;
            if (kind == 2'd3) mdl_depth--;
        end
        e.mask = mdl_mask();
        e.tag  = tag;
        q.push_back(e);
    endtask

    // Monitor: after each edge, compare against the oldest expectation
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " mask"}, {26'd0, active_mask}, {26'd0, e.mask});
            check({e.tag, " ovf"}, {31'd0, err_overflow}, {31'd0, e.ovf});
            check({e.tag, " unf"}, {31'd0, err_underflow}, {31'd0, e.unf});
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LANES; i++) mdl_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 reset mask", {26'd0, active_mask}, {26'd0, {LANES{1'b1}}});
        check("R9 reset errs", {30'd0, err_overflow, err_underflow}, 32'd0);

        // Nested sequence with mixed conditions
        do_ev(2'd1, 6'b001111, "R1 open");
        do_ev(2'd1, 6'b000101, "R2 nested open");
        do_ev(2'd2, 6'b000000, "R3 inner alt");
        do_ev(2'd0, 6'b111111, "R10 idle");
        do_ev(2'd3, 6'b000000, "R4 inner close");
        do_ev(2'd2, 6'b000000, "R3 outer alt");
        do_ev(2'd3, 6'b000000, "R5 outer close");

        // Skip cases: nothing true, and true only on disabled lanes
        do_ev(2'd1, 6'b000000, "R6 none true");
        do_ev(2'd3, 6'b000000, "R5 close");
        do_ev(2'd1, 6'b000011, "R2 open");
        do_ev(2'd1, 6'b111100, "R6 true on idle lanes");
        do_ev(2'd3, 6'b000000, "R4 close");
        do_ev(2'd3, 6'b000000, "R5 close");

        // Underflow at depth zero
        do_ev(2'd3, 6'b000000, "R8 close underflow");
        do_ev(2'd2, 6'b000000, "R8 alt underflow");
        do_ev(2'd0, 6'b000000, "R10 idle after err");

        // Saturation with staggered counts
        do_ev(2'd1, 6'b111110, "R7 fill");
        do_ev(2'd1, 6'b111100, "R7 fill");
        do_ev(2'd1, 6'b111000, "R7 fill");
        for (int k = 0; k < MAXD - 3; k++) do_ev(2'd1, 6'b110000, "R7 fill");
        do_ev(2'd1, 6'b000000, "R7 overflow");
        do_ev(2'd2, 6'b000000, "R3 alt at max");
        do_ev(2'd2, 6'b000000, "R3 alt back");
        for (int k = 0; k < MAXD; k++) do_ev(2'd3, 6'b000000, "R5 unwind");
        do_ev(2'd3, 6'b000000, "R8 extra close");

        // Reset in the middle of nesting
        do_ev(2'd1, 6'b010101, "R2 open");
        do_ev(2'd0, 6'b000000, "R10 idle");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LANES; i++) mdl_cnt[i] = 0;
        mdl_depth = 0;
        #1;
        check("R9 mid reset mask", {26'd0, active_mask}, {26'd0, {LANES{1'b1}}});
        do_ev(2'd3, 6'b000000, "R9 depth cleared");
        do_ev(2'd0, 6'b000000, "R10 idle");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule